// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a two-wire serial bus front end and collects the bytes of one write transaction before storing them. The front end passes it a starting word address and then a stream of data bytes. The block stores each byte in a small page buffer that has a valid flag per slot. After each byte it advances only the low part of its address pointer, so all bytes of a transaction stay inside one page. A stop indication then starts an internal write cycle. During this cycle the block scans the buffer and copies every valid slot into a 2048-byte array that it holds internally.

While the write cycle runs, `busy_o` is high so that the front end can refuse acknowledges. All inputs are ignored during this time. The array write bus is visible on the `commit_*` outputs. A combinational read port lets the surrounding logic inspect the array contents. With the default widths, the 11-bit address is split into a 7-bit page and a 4-bit offset, which gives a 16-byte page.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy_o` and `commit_we_o` are low, and the page buffer holds no valid bytes.
- R2: When `busy_o` is low and `start_i` is high, `start_addr_i[10:4]` is loaded as the page and `start_addr_i[3:0]` as the offset. The next data byte is stored for address `{page, offset}`. Within one cycle, `start_i` has priority over `data_valid_i`, and `data_valid_i` has priority over `stop_i`.
- R3: Each byte accepted with `data_valid_i` increments only the 4-bit offset, modulo 16. The page does not change during a transaction.
- R4: If more than 16 bytes arrive before a stop, the offset rolls over. A later byte replaces the byte buffered earlier at the same offset, and only the last value is committed.
- R5: A transaction that starts in the middle of a page and runs past offset 15 continues at offset 0 of the same page. It never writes into the next page.
- R6: A stop (with `start_i` and `data_valid_i` low) when at least one byte is buffered makes `busy_o` high from the next cycle. `busy_o` then stays high for exactly WR_CYCLES cycles.
- R7: A stop when no byte is buffered leaves `busy_o` low and causes no commit write.
- R8: In busy cycle k, for k from 0 to 15, slot k is presented. `commit_we_o` is high only if slot k is valid. In that case `commit_addr_o` is `{page, k}` and `commit_data_o` is the buffered byte. A single byte followed by a stop gives exactly one commit write.
- R9: While `busy_o` is high, `start_i`, `data_valid_i` and `stop_i` are ignored. Nothing they carry is buffered or committed.
- R10: When the write cycle ends, all valid flags are cleared, so a following bare stop starts no cycle.
- R11: A new start discards any bytes buffered since the previous start.
- R12: `rd_data_o` shows the array byte at `rd_addr_i` combinationally, including bytes written by earlier commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads a new transaction start address |
| start_addr_i | input | 11 | Starting word address |
| data_valid_i | input | 1 | Strobe for one data byte |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop indication from the bus front end |
| busy_o | output | 1 | Internal write cycle in progress |
| commit_we_o | output | 1 | Array write strobe during commit |
| commit_addr_o | output | 11 | Array write address |
| commit_data_o | output | 8 | Array write data |
| rd_addr_i | input | 11 | Array read address |
| rd_data_o | output | 8 | Array read data |

## Verification
A wrong pointer or page register shows up as a wrong `commit_addr_o` in the first busy cycle that presents the affected slot. This happens at most 16 cycles after the stop. A stale or missing valid flag shows up as an extra or missing `commit_we_o` pulse in the same scan. A flag that is not cleared at the end of a cycle appears later, as a busy period after a stop that should have been ignored. A wrong cycle counter changes the length of `busy_o` on the first transaction. The bench's reference model compares all of these every clock, so a fault appears within one write cycle of its cause.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned ADDR_W_DEF    = 11;
  localparam int unsigned DATA_W_DEF    = 8;
  localparam int unsigned OFS_W_DEF     = 4;
  localparam int unsigned WR_CYCLES_DEF = 40;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_LOAD,
    CMD_STEP,
    CMD_GO
  } in_cmd_e;
endpackage

// File: rtl/pwb_addr_ptr.sv
module pwb_addr_ptr #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned OFS_W  = 4,
  localparam int unsigned PAGE_W = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFS_W-1:0]  ofs_o
);
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      ofs_q  <= '0;
    end else if (load_i) begin
      page_q <= addr_i[ADDR_W-1:OFS_W];
      ofs_q  <= addr_i[OFS_W-1:0];
    end else if (step_i) begin
      ofs_q  <= ofs_q + 1'b1;  // wraps inside the page
    end
  end

  assign page_o = page_q;
  assign ofs_o  = ofs_q;
endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFS_W  = 4,
  localparam int unsigned SLOTS = 1 << OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [OFS_W-1:0]  wr_ofs_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFS_W-1:0]  rd_ofs_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              any_valid_o
);
  logic [SLOTS-1:0]  vld_vec;
  logic [DATA_W-1:0] slot_data [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;
    logic              hit;

    assign hit = wr_i && (wr_ofs_i == OFS_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      vld_q <= 1'b0;
      else if (clear_i) vld_q <= 1'b0;
      else if (hit)     vld_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (hit) dat_q <= wr_data_i;
    end

    assign vld_vec[g]   = vld_q;
    assign slot_data[g] = dat_q;
  end

  assign rd_data_o   = slot_data[rd_ofs_i];
  assign rd_valid_o  = vld_vec[rd_ofs_i];
  assign any_valid_o = |vld_vec;
endmodule

// File: rtl/pwb_commit_ctrl.sv
module pwb_commit_ctrl #(
  parameter int unsigned WR_CYCLES = 40,
  parameter int unsigned OFS_W     = 4,
  localparam int unsigned SLOTS  = 1 << OFS_W,
  localparam int unsigned CLOG_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1,
  localparam int unsigned CNT_W  = (CLOG_W > OFS_W + 1) ? CLOG_W : OFS_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  output logic             busy_o,
  output logic             scan_act_o,
  output logic [OFS_W-1:0] scan_ofs_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] SCAN_N = CNT_W'(SLOTS);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done;

  assign done = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end else if (go_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done;
  assign scan_act_o = busy_q && (cnt_q < SCAN_N);
  assign scan_ofs_o = cnt_q[OFS_W-1:0];
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int unsigned ADDR_W    = pwb_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W    = pwb_pkg::DATA_W_DEF,
  parameter int unsigned OFS_W     = pwb_pkg::OFS_W_DEF,
  parameter int unsigned WR_CYCLES = pwb_pkg::WR_CYCLES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              commit_we_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  import pwb_pkg::*;

  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  in_cmd_e           cmd;
  logic              busy;
  logic              any_valid;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              scan_act;
  logic [OFS_W-1:0]  scan_ofs;
  logic              done;
  logic [DATA_W-1:0] slot_data;
  logic              slot_vld;
  logic              load;
  logic              step;

  // priority: start, then data, then stop; nothing while busy
  always_comb begin
    cmd = CMD_NONE;
    if (!busy) begin
      if (start_i)                    cmd = CMD_LOAD;
      else if (data_valid_i)          cmd = CMD_STEP;
      else if (stop_i && any_valid)   cmd = CMD_GO;
    end
  end

  assign load = (cmd == CMD_LOAD);
  assign step = (cmd == CMD_STEP);

  pwb_addr_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (start_addr_i),
    .step_i (step),
    .page_o (page_q),
    .ofs_o  (ofs_q)
  );

  pwb_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (load | done),
    .wr_i        (step),
    .wr_ofs_i    (ofs_q),
    .wr_data_i   (data_i),
    .rd_ofs_i    (scan_ofs),
    .rd_data_o   (slot_data),
    .rd_valid_o  (slot_vld),
    .any_valid_o (any_valid)
  );

  pwb_commit_ctrl #(.WR_CYCLES(WR_CYCLES), .OFS_W(OFS_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (cmd == CMD_GO),
    .busy_o     (busy),
    .scan_act_o (scan_act),
    .scan_ofs_o (scan_ofs),
    .done_o     (done)
  );

  assign commit_we_o   = scan_act && slot_vld;
  assign commit_addr_o = {page_q, scan_ofs};
  assign commit_data_o = slot_data;
  assign busy_o        = busy;

  pwb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk_i     (clk_i),
    .we_i      (commit_we_o),
    .wr_addr_i (commit_addr_o),
    .wr_data_i (commit_data_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int unsigned WR_CYCLES = 40,
  parameter int unsigned PAGE_W    = 7,
  parameter int unsigned OFS_W     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              commit_we_o,
  input logic              start_i,
  input logic              data_valid_i,
  input logic              stop_i,
  input logic              any_valid,
  input logic [PAGE_W-1:0] page,
  input logic [OFS_W-1:0]  ofs
);
  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  assert_we_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_we_o |-> busy_o);

  assert_busy_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len == WR_CYCLES));

  assert_busy_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_len <= WR_CYCLES);

  assert_go_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && stop_i && !start_i && !data_valid_i && any_valid) |=> busy_o);

  assert_idle_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && stop_i && !start_i && !data_valid_i && !any_valid) |=> !busy_o);

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && data_valid_i && !start_i) |=>
      ((ofs == OFS_W'($past(ofs) + 1'b1)) && $stable(page)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(page) && $stable(ofs)));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !any_valid);
endmodule

bind page_write_ctrl pwb_checker #(
  .WR_CYCLES (WR_CYCLES),
  .PAGE_W    (ADDR_W - OFS_W),
  .OFS_W     (OFS_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .commit_we_o  (commit_we_o),
  .start_i      (start_i),
  .data_valid_i (data_valid_i),
  .stop_i       (stop_i),
  .any_valid    (any_valid),
  .page         (page_q),
  .ofs          (ofs_q)
);

// File: tb/page_write_ctrl_tb.sv
module page_write_ctrl_tb;
  localparam int WR = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [10:0] start_addr_i = '0;
  logic        data_valid_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        stop_i = 1'b0;
  logic        busy_o, commit_we_o;
  logic [10:0] commit_addr_o;
  logic [7:0]  commit_data_o;
  logic [10:0] rd_addr_i = '0;
  logic [7:0]  rd_data_o;

  always #4 clk = ~clk;

  page_write_ctrl #(.WR_CYCLES(WR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .data_valid_i(data_valid_i), .data_i(data_i), .stop_i(stop_i),
    .busy_o(busy_o), .commit_we_o(commit_we_o), .commit_addr_o(commit_addr_o),
    .commit_data_o(commit_data_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_page, m_ptr, m_cnt;
  int m_buf[16];
  bit m_val[16];
  bit m_busy;

  function automatic bit m_any();
    foreach (m_val[i]) if (m_val[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_page = 0; m_ptr = 0;
      foreach (m_val[i]) m_val[i] = 0;
    end else if (m_busy) begin
      if (m_cnt == WR - 1) begin
        m_busy = 0;
        foreach (m_val[i]) m_val[i] = 0;
      end else m_cnt++;
    end else if (start_i) begin
      m_page = int'(start_addr_i) / 16;
      m_ptr  = int'(start_addr_i) % 16;
      foreach (m_val[i]) m_val[i] = 0;
    end else if (data_valid_i) begin
      m_buf[m_ptr] = int'(data_i);
      m_val[m_ptr] = 1;
      m_ptr = (m_ptr + 1) % 16;
    end else if (stop_i && m_any()) begin
      m_busy = 1; m_cnt = 0;
    end
  end

  // observed commits
  int sh[int];
  int n_commit, busy_seen;

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_we;
      exp_we = m_busy && (m_cnt < 16) && m_val[m_cnt % 16];
      check(busy_o == m_busy, "R6 busy_o", int'(busy_o), int'(m_busy));
      check(commit_we_o == exp_we, "R8 commit_we_o", int'(commit_we_o), int'(exp_we));
      if (exp_we && commit_we_o) begin
        check(int'(commit_addr_o) == m_page * 16 + m_cnt, "R8 commit_addr_o",
              int'(commit_addr_o), m_page * 16 + m_cnt);
        check(int'(commit_data_o) == m_buf[m_cnt], "R8 commit_data_o",
              int'(commit_data_o), m_buf[m_cnt]);
      end
      if (commit_we_o) begin
        sh[int'(commit_addr_o)] = int'(commit_data_o);
        n_commit++;
      end
      if (busy_o) busy_seen++;
    end
  end

  task automatic new_scn();
    sh.delete(); n_commit = 0; busy_seen = 0;
  endtask

  task automatic do_start(int a);
    @(negedge clk); start_i = 1; start_addr_i = 11'(a);
    @(negedge clk); start_i = 0;
  endtask

  task automatic send(int b);
    @(negedge clk); data_valid_i = 1; data_i = 8'(b);
    @(negedge clk); data_valid_i = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
  endtask

  task automatic settle();
    repeat (WR + 6) @(negedge clk);
  endtask

  function automatic int sh_get(int a);
    return sh.exists(a) ? sh[a] : -1;
  endfunction

  task automatic rd_check(int a, int exp);
    @(negedge clk); rd_addr_i = 11'(a); #1;
    check(int'(rd_data_o) == exp, "R12 rd_data_o", int'(rd_data_o), exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy_o == 0, "R1 busy_o", int'(busy_o), 0);
    check(commit_we_o == 0, "R1 commit_we_o", int'(commit_we_o), 0);
    rst_n = 1;
    do_stop();
    repeat (3) @(negedge clk);
    check(busy_seen == 0, "R1 no data after reset", busy_seen, 0);

    // byte write
    new_scn();
    do_start('h123); send('hA5); do_stop(); settle();
    check(n_commit == 1, "R8 single commit", n_commit, 1);
    check(sh_get('h123) == 'hA5, "R2 byte at start addr", sh_get('h123), 'hA5);
    check(busy_seen == WR, "R6 busy length", busy_seen, WR);
    rd_check('h123, 'hA5);

    // short page write
    new_scn();
    do_start('h200);
    for (int i = 0; i < 4; i++) send('h40 + i);
    do_stop(); settle();
    check(n_commit == 4, "R3 commit count", n_commit, 4);
    check(sh_get('h203) == 'h43, "R3 fourth byte", sh_get('h203), 'h43);
    rd_check('h201, 'h41);

    // mid-page wrap
    new_scn();
    do_start('h3FD);
    for (int i = 0; i < 5; i++) send('h30 + i);
    do_stop(); settle();
    check(sh_get('h3FF) == 'h32, "R5 last slot", sh_get('h3FF), 'h32);
    check(sh_get('h3F0) == 'h33, "R5 wrap to slot 0", sh_get('h3F0), 'h33);
    check(sh_get('h3F1) == 'h34, "R5 wrap to slot 1", sh_get('h3F1), 'h34);
    check(!sh.exists('h400), "R5 next page untouched", sh_get('h400), -1);

    // overflow beyond 16 bytes
    new_scn();
    do_start('h050);
    for (int i = 0; i < 18; i++) send('h10 + i);
    do_stop(); settle();
    check(n_commit == 16, "R4 commit count", n_commit, 16);
    check(sh_get('h050) == 'h20, "R4 overwrite slot 0", sh_get('h050), 'h20);
    check(sh_get('h051) == 'h21, "R4 overwrite slot 1", sh_get('h051), 'h21);
    check(sh_get('h052) == 'h12, "R4 kept slot 2", sh_get('h052), 'h12);
    rd_check('h050, 'h20);

    // stop with no data
    new_scn();
    do_start('h100); do_stop(); repeat (8) @(negedge clk);
    check(busy_seen == 0, "R7 empty stop busy", busy_seen, 0);
    check(n_commit == 0, "R7 empty stop commits", n_commit, 0);

    // inputs during busy
    new_scn();
    do_start('h600); send('h77); do_stop();
    repeat (3) @(negedge clk);
    do_start('h700); send('h99); do_stop();
    settle();
    check(n_commit == 1, "R9 commits", n_commit, 1);
    check(sh_get('h600) == 'h77, "R9 original byte", sh_get('h600), 'h77);
    check(!sh.exists('h700), "R9 ignored start", sh_get('h700), -1);
    busy_seen = 0;
    do_stop(); repeat (8) @(negedge clk);
    check(busy_seen == 0, "R10 flags cleared", busy_seen, 0);

    // restart discards buffered bytes
    new_scn();
    do_start('h010); send('h01); send('h02);
    do_start('h020); send('h03); do_stop(); settle();
    check(n_commit == 1, "R11 commits", n_commit, 1);
    check(sh_get('h020) == 'h03, "R11 new byte", sh_get('h020), 'h03);
    check(!sh.exists('h010), "R11 discarded byte", sh_get('h010), -1);
    rd_check('h123, 'hA5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule